// File: doc/BRIEF.md
# Transactional Commit Write Buffer

This block sits between a processor and a shared broadcast bus. It keeps every store made during an open transaction in a small local buffer, so that no other node can see any of them before the commit. When the processor asks to commit, the block raises an arbitration request and waits. Once the system grants commit permission, the buffer drains on its own. It sends every entry on consecutive cycles as one indivisible packet, with the first and last beats marked, and the processor is free to do other work.

A store to an address that is already held replaces the data in that entry, so each address appears only once in a packet. The packet keeps the order in which each address was first written. If the buffer fills, stores to new addresses stall until the commit. An abort empties the buffer in one cycle and puts nothing on the bus. There is a single bank, so a new transaction can begin only after the previous packet has finished draining.

Top module: `commit_write_buffer`

## Requirements
- R1: After reset, the block is idle. `st_ready_o`, `full_o`, `arb_req_o`, `bc_valid_o`, `bc_first_o`, `bc_last_o` and `commit_done_o` are all 0.
- R2: `tx_begin_i` while idle opens a transaction. `st_ready_o` is high only while a transaction is open. A store offered at any other time is dropped and never appears in a packet. `st_ready_o` is low during a drain.
- R3: `commit_req_i` during an open transaction raises `arb_req_o` from the next cycle until the cycle in which `grant_i` is sampled. Nothing is broadcast before that grant.
- R4: A store to an address already in the buffer overwrites that entry's data and keeps its position. Entries are sent in the order in which each address was first stored.
- R5: When DEPTH entries are held, `full_o` is 1. `st_ready_o` is then 0 for an address not yet held, and stays 1 for an address already held.
- R6: The first beat appears in the cycle after `grant_i` is sampled. One beat is sent per entry, on consecutive cycles, with `bc_addr_o` and `bc_data_o` taken from the entry.
- R7: `bc_first_o` marks the first beat and `bc_last_o` marks the last beat. In a packet of one entry, both markers are high on the same beat.
- R8: `commit_done_o` is a one-cycle pulse in the cycle after the last beat. For a transaction with no stores, it pulses in the cycle after the grant and no beat is sent.
- R9: `abort_i` during an open transaction, or while waiting for the grant, returns the block to idle in one cycle. It discards all entries, including any store offered in the same cycle, and sends nothing. The next transaction starts empty.
- R10: `abort_i` is ignored once draining has started, and the packet completes. `tx_begin_i` is ignored when the block is not idle.
- R11: A store accepted in the same cycle as `commit_req_i` is included in the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_begin_i | input | 1 | Open a transaction (idle only) |
| st_valid_i | input | 1 | Store offered |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| st_ready_o | output | 1 | Store accepted this cycle when valid |
| full_o | output | 1 | All DEPTH entries in use |
| commit_req_i | input | 1 | Close the transaction and ask to commit |
| abort_i | input | 1 | Discard the transaction |
| arb_req_o | output | 1 | Waiting for commit permission |
| grant_i | input | 1 | System-wide commit permission |
| bc_valid_o | output | 1 | Broadcast beat valid |
| bc_first_o | output | 1 | First beat of the packet |
| bc_last_o | output | 1 | Last beat of the packet |
| bc_addr_o | output | AW | Beat address |
| bc_data_o | output | DW | Beat data |
| commit_done_o | output | 1 | Packet finished (one-cycle pulse) |

## Verification
Several properties are checked on every cycle:
- the fill count never exceeds DEPTH;
- a packet opens only after a sampled grant;
- beats are contiguous until the last-beat marker;
- the done pulse follows the last beat and lasts one cycle;
- an abort while waiting leaves the bus silent;
- stores are refused during a drain.

Some behaviour only the bench's scenarios can show:
- data coalescing for a repeated address;
- the first-store ordering of beats;
- stall and accept decisions at a full buffer;
- inclusion of a store made in the commit cycle;
- empty commits;
- that a discarded or idle-time store never reaches a later packet.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OPEN  = 2'd1,
    S_WAIT  = 2'd2,
    S_DRAIN = 2'd3
  } twb_state_e;
endpackage

// File: rtl/twb_store.sv
module twb_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          hit_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [CW-1:0]    count_q;
  logic [DEPTH-1:0] match;
  logic [IW-1:0]    hit_idx;
  logic [IW-1:0]    wr_idx;

  // one comparator per live entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = (CW'(i) < count_q) && (addr_q[i] == addr_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit_o  = |match;
  assign full_o = (count_q == CW'(DEPTH));
  assign wr_idx = hit_o ? hit_idx : count_q[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (wr_en_i && !hit_o) begin
      count_q <= count_q + CW'(1);
    end
  end

  // storage is not reset; only entries below count_q are ever read
  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clear_i) begin
      addr_q[wr_idx] <= addr_i;
      data_q[wr_idx] <= data_i;
    end
  end

  assign count_o   = count_q;
  assign rd_addr_o = addr_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
  import twb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_begin_i,
  input  logic          commit_req_i,
  input  logic          abort_i,
  input  logic          grant_i,
  input  logic [CW-1:0] count_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          clear_o,
  output logic          open_o,
  output logic          arb_req_o,
  output logic          bc_valid_o,
  output logic          bc_first_o,
  output logic          bc_last_o,
  output logic          done_o
);
  twb_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic          last_beat;
  logic          abort_acc;
  logic          begin_acc;

  assign last_beat = (state_q == S_DRAIN) && ((CW'(idx_q) + CW'(1)) == count_i);
  assign abort_acc = abort_i && ((state_q == S_OPEN) || (state_q == S_WAIT));
  assign begin_acc = tx_begin_i && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: if (tx_begin_i) state_d = S_OPEN;
      S_OPEN: begin
        if (abort_i)           state_d = S_IDLE;
        else if (commit_req_i) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (abort_i) begin
          state_d = S_IDLE;
        end else if (grant_i) begin
          if (count_i == '0) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = S_DRAIN;
            idx_d   = '0;
          end
        end
      end
      S_DRAIN: begin
        if (last_beat) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign clear_o    = begin_acc || abort_acc || last_beat;
  assign open_o     = (state_q == S_OPEN);
  assign arb_req_o  = (state_q == S_WAIT);
  assign bc_valid_o = (state_q == S_DRAIN);
  assign bc_first_o = bc_valid_o && (idx_q == '0);
  assign bc_last_o  = last_beat;
  assign rd_idx_o   = idx_q;
  assign done_o     = done_q;
endmodule

// File: rtl/commit_write_buffer.sv
module commit_write_buffer #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_begin_i,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic          st_ready_o,
  output logic          full_o,
  input  logic          commit_req_i,
  input  logic          abort_i,
  output logic          arb_req_o,
  input  logic          grant_i,
  output logic          bc_valid_o,
  output logic          bc_first_o,
  output logic          bc_last_o,
  output logic [AW-1:0] bc_addr_o,
  output logic [DW-1:0] bc_data_o,
  output logic          commit_done_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = $clog2(DEPTH);

  logic          hit, full, open, clear, wr_en;
  logic [CW-1:0] count;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  // a held address can still be rewritten when full
  assign st_ready_o = open && (!full || hit);
  assign wr_en      = st_valid_i && st_ready_o && !abort_i;
  assign full_o     = full;

  twb_store #(
    .DEPTH(DEPTH),
    .AW   (AW),
    .DW   (DW)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .wr_en_i  (wr_en),
    .addr_i   (st_addr_i),
    .data_i   (st_data_i),
    .rd_idx_i (rd_idx),
    .hit_o    (hit),
    .full_o   (full),
    .count_o  (count),
    .rd_addr_o(rd_addr),
    .rd_data_o(rd_data)
  );

  twb_ctrl #(
    .DEPTH(DEPTH)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_begin_i  (tx_begin_i),
    .commit_req_i(commit_req_i),
    .abort_i     (abort_i),
    .grant_i     (grant_i),
    .count_i     (count),
    .rd_idx_o    (rd_idx),
    .clear_o     (clear),
    .open_o      (open),
    .arb_req_o   (arb_req_o),
    .bc_valid_o  (bc_valid_o),
    .bc_first_o  (bc_first_o),
    .bc_last_o   (bc_last_o),
    .done_o      (commit_done_o)
  );

  assign bc_addr_o = bc_valid_o ? rd_addr : '0;
  assign bc_data_o = bc_valid_o ? rd_data : '0;
endmodule

// File: rtl/twb_chk.sv
module twb_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          st_ready_o,
  input logic          full_o,
  input logic          abort_i,
  input logic          arb_req_o,
  input logic          grant_i,
  input logic          bc_valid_o,
  input logic          bc_first_o,
  input logic          bc_last_o,
  input logic          commit_done_o,
  input logic [CW-1:0] count_i
);
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && st_valid_i && st_ready_o && !abort_i |=> full_o);

  // R3
  grant_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_first_o |-> $past(grant_i && arb_req_o));

  // R7
  rise_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bc_valid_o) |-> bc_first_o);

  // R6
  beat_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_o && !bc_last_o |=> bc_valid_o && !bc_first_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_last_o |=> commit_done_o && !bc_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done_o |=> !commit_done_o);

  // R9
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && arb_req_o |=> !arb_req_o && !bc_valid_o);

  // R2
  drain_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_o |-> !st_ready_o);
endmodule

bind commit_write_buffer twb_chk #(
  .DEPTH(DEPTH),
  .CW   (CW)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_valid_i   (st_valid_i),
  .st_ready_o   (st_ready_o),
  .full_o       (full_o),
  .abort_i      (abort_i),
  .arb_req_o    (arb_req_o),
  .grant_i      (grant_i),
  .bc_valid_o   (bc_valid_o),
  .bc_first_o   (bc_first_o),
  .bc_last_o    (bc_last_o),
  .commit_done_o(commit_done_o),
  .count_i      (count)
);

// File: tb/test_commit_write_buffer.sv
`timescale 1ns/1ps
module test_commit_write_buffer;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0, rst_ni = 0;
  logic tx_begin = 0, st_valid = 0, commit_req = 0, abort = 0, grant = 0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, full, arb_req, bc_valid, bc_first, bc_last, done;
  logic [AW-1:0] bc_addr;
  logic [DW-1:0] bc_data;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  commit_write_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_commit_write_buffer (
    .clk_i(clk), .rst_ni(rst_ni), .tx_begin_i(tx_begin),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
    .st_ready_o(st_ready), .full_o(full), .commit_req_i(commit_req),
    .abort_i(abort), .arb_req_o(arb_req), .grant_i(grant),
    .bc_valid_o(bc_valid), .bc_first_o(bc_first), .bc_last_o(bc_last),
    .bc_addr_o(bc_addr), .bc_data_o(bc_data), .commit_done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", req, $time, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 open, 2 wait, 3 drain
  int m_st = 0, m_idx = 0, hidx = 0;
  bit m_done = 0, nd = 0;
  logic [AW-1:0] m_a[$];
  logic [DW-1:0] m_d[$];

  function automatic int find(input logic [AW-1:0] a);
    foreach (m_a[i]) if (m_a[i] == a) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_idx = 0; m_done = 0; m_a.delete(); m_d.delete();
    end else begin
      nd = 0;
      hidx = find(st_addr);
      case (m_st)
        0: if (tx_begin) m_st = 1;
        1: if (abort) begin
             m_a.delete(); m_d.delete(); m_st = 0;
           end else begin
             if (st_valid && (m_a.size() < DEPTH || hidx >= 0)) begin
               if (hidx >= 0) m_d[hidx] = st_data;
               else begin m_a.push_back(st_addr); m_d.push_back(st_data); end
             end
             if (commit_req) m_st = 2;
           end
        2: if (abort) begin
             m_a.delete(); m_d.delete(); m_st = 0;
           end else if (grant) begin
             if (m_a.size() == 0) begin nd = 1; m_st = 0; end
             else begin m_st = 3; m_idx = 0; end
           end
        default: if (m_idx == m_a.size() - 1) begin
             nd = 1; m_a.delete(); m_d.delete(); m_st = 0;
           end else m_idx++;
      endcase
      m_done = nd;
    end
  end

  // per-cycle comparison and packet capture
  logic [AW-1:0] cap_a[$];
  logic [DW-1:0] cap_d[$];
  bit cap_f[$], cap_l[$];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      bit e_full, e_ready;
      e_full  = (m_a.size() == DEPTH);
      e_ready = (m_st == 1) && (!e_full || find(st_addr) >= 0);
      chk("R2 st_ready", 32'(st_ready), 32'(e_ready));
      chk("R5 full", 32'(full), 32'(e_full));
      chk("R3 arb_req", 32'(arb_req), 32'(m_st == 2));
      chk("R6 bc_valid", 32'(bc_valid), 32'(m_st == 3));
      chk("R8 commit_done", 32'(done), 32'(m_done));
      if (m_st == 3) begin
        chk("R7 first", 32'(bc_first), 32'(m_idx == 0));
        chk("R7 last", 32'(bc_last), 32'(m_idx == m_a.size() - 1));
        chk("R6 addr", 32'(bc_addr), 32'(m_a[m_idx]));
        chk("R6 data", 32'(bc_data), 32'(m_d[m_idx]));
      end
      if (bc_valid) begin
        cap_a.push_back(bc_addr); cap_d.push_back(bc_data);
        cap_f.push_back(bc_first); cap_l.push_back(bc_last);
      end
      if (done) done_cnt++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cap_clear();
    cap_a.delete(); cap_d.delete(); cap_f.delete(); cap_l.delete();
  endtask

  task automatic do_begin();
    tx_begin = 1; tick(); tx_begin = 0;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_valid = 1; st_addr = a; st_data = d; tick(); st_valid = 0;
  endtask

  task automatic do_commit();
    commit_req = 1; tick(); commit_req = 0;
  endtask

  task automatic do_grant();
    grant = 1; tick(); grant = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 st_ready", 32'(st_ready), 0);
    chk("R1 full", 32'(full), 0);
    chk("R1 arb_req", 32'(arb_req), 0);
    chk("R1 bc_valid", 32'(bc_valid|bc_first|bc_last), 0);
    chk("R1 done", 32'(done), 0);
    tick();

    // R2: store while idle is dropped
    st_valid = 1; st_addr = 8'h05; st_data = 16'hdead; #1;
    chk("R2 idle refuses store", 32'(st_ready), 0);
    tick(); st_valid = 0;
    cap_clear(); d0 = done_cnt;
    do_begin(); do_commit(); do_grant(); tick(); tick();
    chk("R2 idle store absent", cap_a.size(), 0);
    chk("R8 empty commit done", done_cnt - d0, 1);

    // R3 R4 R6 R7: coalescing and ordering
    cap_clear(); d0 = done_cnt;
    do_begin();
    do_store(8'h0A, 16'h0001);
    do_store(8'h0B, 16'h0002);
    do_store(8'h0A, 16'h0003);
    do_store(8'h0C, 16'h0004);
    do_commit();
    repeat (3) tick();
    chk("R3 no beat before grant", cap_a.size(), 0);
    chk("R3 arb_req held", 32'(arb_req), 1);
    do_grant(); repeat (4) tick();
    chk("R6 beat count", cap_a.size(), 3);
    if (cap_a.size() == 3) begin
      chk("R4 order a0", 32'(cap_a[0]), 32'h0A);
      chk("R4 order a1", 32'(cap_a[1]), 32'h0B);
      chk("R4 order a2", 32'(cap_a[2]), 32'h0C);
      chk("R4 coalesced data", 32'(cap_d[0]), 32'h0003);
      chk("R6 data b", 32'(cap_d[1]), 32'h0002);
      chk("R7 first marks", 32'({cap_f[0], cap_f[1], cap_f[2]}), 32'b100);
      chk("R7 last marks", 32'({cap_l[0], cap_l[1], cap_l[2]}), 32'b001);
    end
    chk("R8 done once", done_cnt - d0, 1);

    // R5 R11: full buffer and store in commit cycle
    cap_clear();
    do_begin();
    do_store(8'h10, 16'h0011);
    do_store(8'h11, 16'h0022);
    do_store(8'h12, 16'h0033);
    do_store(8'h13, 16'h0044);
    chk("R5 full flag", 32'(full), 1);
    st_valid = 1; st_addr = 8'h14; st_data = 16'h0055; #1;
    chk("R5 stall new addr", 32'(st_ready), 0);
    tick();
    st_addr = 8'h12; st_data = 16'h0099; #1;
    chk("R5 accept held addr", 32'(st_ready), 1);
    commit_req = 1; tick(); commit_req = 0; st_valid = 0;
    do_grant(); repeat (6) tick();
    chk("R5 beat count", cap_a.size(), 4);
    if (cap_a.size() == 4) begin
      chk("R11 commit-cycle store", 32'(cap_d[2]), 32'h0099);
      chk("R5 stalled addr absent", 32'(cap_a[3]), 32'h13);
    end

    // R7: single-entry packet
    cap_clear();
    do_begin(); do_store(8'h20, 16'h0007); do_commit(); do_grant(); repeat (3) tick();
    chk("R7 single beat", cap_a.size(), 1);
    if (cap_a.size() == 1) chk("R7 first and last", 32'({cap_f[0], cap_l[0]}), 32'b11);

    // R9: abort while open, with store in abort cycle
    cap_clear(); d0 = done_cnt;
    do_begin(); do_store(8'h30, 16'h0001); do_store(8'h31, 16'h0002);
    st_valid = 1; st_addr = 8'h32; st_data = 16'h0003; abort = 1;
    tick(); st_valid = 0; abort = 0;
    tick();
    chk("R9 idle after abort", 32'(st_ready), 0);
    // R9: abort while waiting for grant
    do_begin(); do_store(8'h33, 16'h0005); do_commit(); tick();
    abort = 1; grant = 1; tick(); abort = 0; grant = 0;
    repeat (3) tick();
    chk("R9 no beats after abort", cap_a.size(), 0);
    chk("R9 arb dropped", 32'(arb_req), 0);
    chk("R9 no done after abort", done_cnt - d0, 0);
    do_begin(); do_store(8'h40, 16'h0abc); do_commit(); do_grant(); repeat (3) tick();
    chk("R9 next tx empty start", cap_a.size(), 1);
    if (cap_a.size() == 1) chk("R9 next tx addr", 32'(cap_a[0]), 32'h40);

    // R10: abort and begin ignored during drain
    cap_clear();
    do_begin(); do_store(8'h50, 16'h1); do_store(8'h51, 16'h2); do_store(8'h52, 16'h3);
    do_commit(); do_grant();
    abort = 1; tx_begin = 1; tick(); abort = 0; tx_begin = 0;
    repeat (4) tick();
    chk("R10 packet completes", cap_a.size(), 3);
    st_valid = 1; st_addr = 8'h60; #1;
    chk("R10 begin ignored", 32'(st_ready), 0);
    tick(); st_valid = 0;
    repeat (2) tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule